// File: doc/BRIEF.md
# Multi-Mode Receive Line Input Front End

This block is the first stage in the receive path of a DS3/E3 framer. Two shared input pins carry different information depending on the configured line mode. In the bipolar line-code modes (B3ZS, HDB3 or AMI), the first pin is a positive-pulse indicator and the second pin is a negative-pulse indicator, both supplied by an external line receiver. In unipolar mode, the first pin carries receive data that has already been decoded, and the second pin flags line-code violations. In overhead-mask mode, the first pin is again data, and the second pin marks bit positions that belong to overhead and must not be passed on as payload.

Each of the two pins and the sampling clock has its own static polarity-invert control. The sampling clock is normally the external line clock. A select bit can switch it to the recovered receive clock, and that clock is always used while the internal line interface is enabled. When the clock is inverted, sampling happens on the falling edge. A small state machine follows the mode and shapes the outputs:

- the sampled positive and negative rails;
- the receive data with a data-valid qualifier;
- a saturating violation counter with a latch-and-clear holding register.

Top module: `rxf_line_front`

## Requirements
- R1: While `rst_n` is low, and after its release until the first sampling edge, every output is zero.
- R2: With `mode` = 00 (bipolar), each sampling edge sets `pos_rail` to the effective first pin and `neg_rail` to the effective second pin; `rx_data` is 0 and `rx_valid` is 1.
- R3: With `mode` = 01 (unipolar), each sampling edge sets `rx_data` to the effective first pin with `rx_valid` 1; both rails are 0.
- R4: With `mode` = 01, `viol_cnt` rises by exactly one on every sampling edge at which the effective second pin is 1.
- R5: With `mode` = 10 or 11 (overhead mask), an edge with the effective second pin at 1 gives `rx_valid` 0 and `rx_data` 0; with it at 0, `rx_data` follows the first pin and `rx_valid` is 1; both rails are 0.
- R6: In every mode other than 01, the second pin has no effect on `viol_cnt`.
- R7: `a_inv` and `b_inv` invert the first and second pins before sampling (effective value = pin XOR invert bit).
- R8: With `clk_inv` = 1, inputs are sampled on the falling edge of the selected clock; between sampling edges the outputs hold.
- R9: With `sel_rec` = 1, `rec_clk` is the sampling clock and `line_clk` is ignored.
- R10: With `lif_en` = 1, `line_clk` is ignored and `rec_clk` is the sampling clock, whatever `sel_rec` is.
- R11: A sampling edge with `latch_clr` = 1 copies the current `viol_cnt` into `viol_hold` and restarts `viol_cnt` at that edge's own increment (0 or 1).
- R12: `viol_cnt` (CNT_W bits, 16 by default) saturates at all ones and stays there until a latch-and-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk | input | 1 | External receive line clock |
| rec_clk | input | 1 | Recovered receive clock |
| lif_en | input | 1 | Internal line interface enabled; forces rec_clk |
| sel_rec | input | 1 | Select rec_clk as sampling clock |
| clk_inv | input | 1 | Invert the selected clock (falling-edge sampling) |
| pin_a | input | 1 | Positive pulse or receive data |
| pin_b | input | 1 | Negative pulse, violation flag or overhead marker |
| a_inv | input | 1 | Invert pin_a |
| b_inv | input | 1 | Invert pin_b |
| mode | input | 2 | 00 bipolar, 01 unipolar, 10/11 overhead mask |
| latch_clr | input | 1 | Copy count to holding register and clear |
| pos_rail | output | 1 | Sampled positive rail (bipolar only) |
| neg_rail | output | 1 | Sampled negative rail (bipolar only) |
| rx_data | output | 1 | Sampled payload data |
| rx_valid | output | 1 | Qualifier for rx_data |
| viol_cnt | output | CNT_W | Running violation count |
| viol_hold | output | CNT_W | Count captured at the last latch-and-clear |

## Verification
The checker tests these properties on every sampling edge:

- the rail, data and qualifier shape required by each mode;
- the suppression of masked overhead bits;
- the one-step increment of the counter in unipolar mode;
- the counter standing still in the other modes;
- saturation, and the hand-over of the count to the holding register.

Some behaviours can only be shown by the bench scenarios, because they concern which clock edge is used rather than what happens at it. These are:

- falling-edge sampling under clock inversion;
- the choice between the line clock and the recovered clock;
- the line clock being ignored while the internal interface is enabled;
- the per-pin inversions.

The bench checks them by observing the outputs both between edges and just after them.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        MODE_BIPOLAR  = 2'b00,
        MODE_UNIPOLAR = 2'b01,
        MODE_MASK     = 2'b10,
        MODE_MASK_ALT = 2'b11
    } rx_mode_e;

    typedef enum logic [1:0] {
        ST_RESET    = 2'd0,
        ST_BIPOLAR  = 2'd1,
        ST_UNIPOLAR = 2'd2,
        ST_MASKED   = 2'd3
    } rx_state_e;

    // Next state of the interpretation FSM for a given configured mode
    function automatic rx_state_e next_state(input logic [1:0] m);
        rx_state_e s;
        unique case (m)
            2'b00:   s = ST_BIPOLAR;
            2'b01:   s = ST_UNIPOLAR;
            default: s = ST_MASKED;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rxf_clk_sel.sv
module rxf_clk_sel (
    input  logic line_clk,
    input  logic rec_clk,
    input  logic lif_en,
    input  logic sel_rec,
    input  logic clk_inv,
    output logic smp_clk
);
    logic use_rec;
    logic picked;

    // Line clock is ignored whenever the internal interface drives the path
    assign use_rec = lif_en | sel_rec;
    assign picked  = use_rec ? rec_clk : line_clk;
    assign smp_clk = picked ^ clk_inv;
endmodule

// File: rtl/rxf_pin_sampler.sv
module rxf_pin_sampler #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin,
    input  logic [NPIN-1:0] inv,
    output logic [NPIN-1:0] eff,
    output logic [NPIN-1:0] q
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pol
        assign eff[i] = pin[i] ^ inv[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= eff;
        end
    end
endmodule

// File: rtl/rxf_viol_counter.sv
module rxf_viol_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             latch_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] hold
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] inc_w;
    assign inc_w = CNT_W'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            hold <= '0;
        end else if (latch_clr) begin
            hold <= cnt;
            cnt  <= inc_w;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rxf_line_front.sv
module rxf_line_front
    import rxf_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             rst_n,
    input  logic             line_clk,
    input  logic             rec_clk,
    input  logic             lif_en,
    input  logic             sel_rec,
    input  logic             clk_inv,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             a_inv,
    input  logic             b_inv,
    input  logic [1:0]       mode,
    input  logic             latch_clr,
    output logic             pos_rail,
    output logic             neg_rail,
    output logic             rx_data,
    output logic             rx_valid,
    output logic [CNT_W-1:0] viol_cnt,
    output logic [CNT_W-1:0] viol_hold
);
    localparam int NPIN = 2;
    localparam int IA   = 0;
    localparam int IB   = 1;

    logic            smp_clk;
    logic [NPIN-1:0] pin_eff;
    logic [NPIN-1:0] pin_q;
    logic            viol_inc;
    rx_state_e       state_q;
    rx_state_e       state_d;

    rxf_clk_sel u_clk_sel (
        .line_clk (line_clk),
        .rec_clk  (rec_clk),
        .lif_en   (lif_en),
        .sel_rec  (sel_rec),
        .clk_inv  (clk_inv),
        .smp_clk  (smp_clk)
    );

    rxf_pin_sampler #(.NPIN(NPIN)) u_sampler (
        .clk   (smp_clk),
        .rst_n (rst_n),
        .pin   ({pin_b, pin_a}),
        .inv   ({b_inv, a_inv}),
        .eff   (pin_eff),
        .q     (pin_q)
    );

    // Violation flag only has meaning in unipolar mode
    assign viol_inc = (rx_mode_e'(mode) == MODE_UNIPOLAR) && pin_eff[IB];

    rxf_viol_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (smp_clk),
        .rst_n     (rst_n),
        .inc       (viol_inc),
        .latch_clr (latch_clr),
        .cnt       (viol_cnt),
        .hold      (viol_hold)
    );

    // Transitions: ST_RESET -> mode state on first edge; any -> mode state each edge
    assign state_d = next_state(mode);

    always_ff @(posedge smp_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pos_rail = 1'b0;
        neg_rail = 1'b0;
        rx_data  = 1'b0;
        rx_valid = 1'b0;
        unique case (state_q)
            ST_RESET: begin
            end
            ST_BIPOLAR: begin
                pos_rail = pin_q[IA];
                neg_rail = pin_q[IB];
                rx_valid = 1'b1;
            end
            ST_UNIPOLAR: begin
                rx_data  = pin_q[IA];
                rx_valid = 1'b1;
            end
            ST_MASKED: begin
                rx_data  = pin_q[IA] & ~pin_q[IB];
                rx_valid = ~pin_q[IB];
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/rxf_line_front_chk.sv
module rxf_line_front_chk #(
    parameter int CNT_W = 16
) (
    input logic             smp_clk,
    input logic             rst_n,
    input logic             pin_b,
    input logic             b_inv,
    input logic [1:0]       mode,
    input logic             latch_clr,
    input logic             pos_rail,
    input logic             neg_rail,
    input logic             rx_data,
    input logic             rx_valid,
    input logic [CNT_W-1:0] viol_cnt,
    input logic [CNT_W-1:0] viol_hold
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    assert_bipolar_shape_R2: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (rx_valid && !rx_data));

    assert_unipolar_rails_R3: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (rx_valid && !pos_rail && !neg_rail));

    assert_count_step_R4: assert property (@(posedge smp_clk) disable iff (!rst_n)
        ((mode == 2'b01) && (pin_b ^ b_inv) && !latch_clr && (viol_cnt != CMAX))
        |=> (viol_cnt == $past(viol_cnt) + 1'b1));

    assert_mask_drop_R5: assert property (@(posedge smp_clk) disable iff (!rst_n)
        (mode[1] && (pin_b ^ b_inv)) |=> (!rx_valid && !rx_data && !pos_rail && !neg_rail));

    assert_count_still_R6: assert property (@(posedge smp_clk) disable iff (!rst_n)
        ((mode != 2'b01) && !latch_clr) |=> $stable(viol_cnt));

    assert_hold_copy_R11: assert property (@(posedge smp_clk) disable iff (!rst_n)
        latch_clr |=> ((viol_hold == $past(viol_cnt)) && (viol_cnt <= 1)));

    assert_no_overflow_R12: assert property (@(posedge smp_clk) disable iff (!rst_n)
        ((viol_cnt == CMAX) && !latch_clr) |=> (viol_cnt == CMAX));
endmodule

bind rxf_line_front rxf_line_front_chk #(.CNT_W(CNT_W)) u_chk (
    .smp_clk   (smp_clk),
    .rst_n     (rst_n),
    .pin_b     (pin_b),
    .b_inv     (b_inv),
    .mode      (mode),
    .latch_clr (latch_clr),
    .pos_rail  (pos_rail),
    .neg_rail  (neg_rail),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .viol_cnt  (viol_cnt),
    .viol_hold (viol_hold)
);

// File: tb/rxf_line_front_tb.sv
module rxf_line_front_tb;
    localparam int CW = 8;

    logic rst_n = 1'b0, line_clk = 1'b0, rec_clk = 1'b0;
    logic lif_en = 1'b0, sel_rec = 1'b0, clk_inv = 1'b0;
    logic pin_a = 1'b0, pin_b = 1'b0, a_inv = 1'b0, b_inv = 1'b0, latch_clr = 1'b0;
    logic [1:0] mode = 2'b00;
    logic pos_rail, neg_rail, rx_data, rx_valid;
    logic [CW-1:0] viol_cnt, viol_hold;

    rxf_line_front #(.CNT_W(CW)) u_dut (
        .rst_n(rst_n), .line_clk(line_clk), .rec_clk(rec_clk), .lif_en(lif_en),
        .sel_rec(sel_rec), .clk_inv(clk_inv), .pin_a(pin_a), .pin_b(pin_b),
        .a_inv(a_inv), .b_inv(b_inv), .mode(mode), .latch_clr(latch_clr),
        .pos_rail(pos_rail), .neg_rail(neg_rail), .rx_data(rx_data), .rx_valid(rx_valid),
        .viol_cnt(viol_cnt), .viol_hold(viol_hold)
    );

    always #10 line_clk = ~line_clk;   // 50 MHz
    always #15 rec_clk  = ~rec_clk;

    logic smp_tb;
    assign smp_tb = ((lif_en | sel_rec) ? rec_clk : line_clk) ^ clk_inv;

    typedef struct packed {
        logic pos; logic neg; logic data; logic valid;
        logic [CW-1:0] cnt; logic [CW-1:0] hold;
    } exp_t;

    int checks = 0;
    int errors = 0;
    exp_t exp_q[$];
    string tag_q[$];
    exp_t prev;
    bit prev_ok = 1'b0;
    logic [CW-1:0] m_cnt = '0;
    logic [CW-1:0] m_hold = '0;
    event ev_chk;

    task automatic check_out(input exp_t e, input string tag);
        exp_t got;
        got = '{pos_rail, neg_rail, rx_data, rx_valid, viol_cnt, viol_hold};
        checks++;
        if (got !== e) begin
            errors++;
            $display("FAIL %s: got pos=%b neg=%b data=%b valid=%b cnt=%0d hold=%0d, exp pos=%b neg=%b data=%b valid=%b cnt=%0d hold=%0d",
                     tag, got.pos, got.neg, got.data, got.valid, got.cnt, got.hold,
                     e.pos, e.neg, e.data, e.valid, e.cnt, e.hold);
        end
    endtask

    task automatic step(input logic a, input logic b, input logic lc, input string tag);
        exp_t e;
        logic ae, be, inc;
        pin_a = a; pin_b = b; latch_clr = lc;
        if (prev_ok) begin
            @(negedge smp_tb); #1;
            check_out(prev, {tag, " between-edge hold R8"});
        end
        @(posedge smp_tb);
        ae  = a ^ a_inv;
        be  = b ^ b_inv;
        inc = (mode == 2'b01) && be;
        if (lc) begin
            m_hold = m_cnt;
            m_cnt  = inc ? CW'(1) : '0;
        end else if (inc && (m_cnt != '1)) begin
            m_cnt = m_cnt + 1'b1;
        end
        e.cnt = m_cnt; e.hold = m_hold;
        case (mode)
            2'b00:   begin e.pos = ae;   e.neg = be;   e.data = 1'b0; e.valid = 1'b1; end
            2'b01:   begin e.pos = 1'b0; e.neg = 1'b0; e.data = ae;   e.valid = 1'b1; end
            default: begin e.pos = 1'b0; e.neg = 1'b0; e.data = ae & ~be; e.valid = ~be; end
        endcase
        #2;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> ev_chk;
        #1;
        prev = e;
        prev_ok = 1'b1;
    endtask

    // Safe reconfiguration: bipolar mode, so no edge can move the counter
    task automatic reconfig(input logic li, input logic sr, input logic ci,
                            input logic ai, input logic bi);
        mode = 2'b00; pin_a = 1'b0; pin_b = 1'b0; latch_clr = 1'b0;
        #1;
        lif_en = li; sel_rec = sr; clk_inv = ci; a_inv = ai; b_inv = bi;
        repeat (3) @(posedge smp_tb);
        #2;
        prev_ok = 1'b0;
    endtask

    // Monitor: pops expected items as the design produces results
    initial begin
        forever begin
            @(ev_chk);
            while (exp_q.size() > 0) begin
                check_out(exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #5;
        check_out('0, "R1 in reset");
        #50 rst_n = 1'b1;
        #5;
        check_out('0, "R1 after release before edge");

        mode = 2'b00;
        step(1, 0, 0, "R2 bipolar");
        step(0, 1, 0, "R2 bipolar");
        step(1, 1, 0, "R2 bipolar");
        step(0, 0, 0, "R2 bipolar");

        mode = 2'b01;
        step(1, 1, 0, "R3 R4 unipolar");
        step(0, 1, 0, "R3 R4 unipolar");
        step(1, 0, 0, "R3 R4 unipolar");
        step(0, 0, 0, "R3 R4 unipolar");
        step(1, 1, 0, "R3 R4 unipolar");

        mode = 2'b10;
        step(1, 0, 0, "R5 R6 mask");
        step(1, 1, 0, "R5 R6 mask");
        step(0, 1, 0, "R5 R6 mask");
        step(1, 0, 0, "R5 R6 mask");
        mode = 2'b11;
        step(1, 1, 0, "R5 mask alt");
        step(1, 0, 0, "R5 mask alt");

        mode = 2'b00;
        step(0, 1, 0, "R6 bipolar no count");
        step(1, 1, 0, "R6 bipolar no count");

        reconfig(0, 0, 0, 1, 1);
        mode = 2'b01;
        step(0, 0, 0, "R7 inverted pins");
        step(1, 1, 0, "R7 inverted pins");
        step(0, 1, 0, "R7 inverted pins");
        mode = 2'b00;
        step(0, 1, 0, "R7 inverted rails");
        step(1, 0, 0, "R7 inverted rails");

        reconfig(0, 0, 1, 0, 0);
        mode = 2'b01;
        step(1, 1, 0, "R8 falling edge");
        step(0, 0, 0, "R8 falling edge");
        step(1, 0, 0, "R8 falling edge");
        step(0, 1, 0, "R8 falling edge");

        reconfig(0, 1, 0, 0, 0);
        mode = 2'b01;
        step(1, 1, 0, "R9 recovered clock");
        step(0, 0, 0, "R9 recovered clock");
        step(1, 0, 0, "R9 recovered clock");
        step(0, 1, 0, "R9 recovered clock");

        reconfig(1, 0, 0, 0, 0);
        mode = 2'b01;
        step(1, 0, 0, "R10 line clock ignored");
        step(0, 1, 0, "R10 line clock ignored");
        step(1, 1, 0, "R10 line clock ignored");
        step(0, 0, 0, "R10 line clock ignored");

        reconfig(0, 0, 0, 0, 0);
        mode = 2'b01;
        step(1, 1, 1, "R11 latch with increment");
        step(0, 0, 1, "R11 latch no increment");
        step(0, 1, 0, "R11 count after latch");

        for (int i = 0; i < 300; i++) begin
            step(0, 1, 0, "R12 saturation");
        end
        step(0, 0, 0, "R12 saturated idle");
        step(0, 1, 1, "R12 latch saturated");
        step(0, 1, 0, "R12 count restarts");

        #5;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule